// File: doc/BRIEF.md
# Context-Tagged Translation Cache

This block is a small, fully associative store of completed I/O address translations. It sits inside an I/O memory management unit. Each entry maps a 4 KiB virtual page number to a physical page number. It also keeps three permission bits and a two-bit memory type. Each entry carries a guest context tag and a process context tag, and each tag has its own valid flag.

The tags are identifiers that software assigns. They are not device numbers, so several devices that share an address space hit the same entry. All devices with a given guest identifier must use the same second-stage tables. For that reason, an entry with no process tag serves every process under its guest tag.

A lookup gives a hit, with the cached translation, in the same cycle it is presented. Fills arrive from a translation walker. A fill whose key is already present is rewritten in place. A fill for a new key goes to the slot under a round-robin victim pointer. Software brings the cache back in line after it edits translation tables, using invalidation commands of four scopes. Each command returns a completion pulse.

Top module: `xlat_ctx_cache`

## Requirements
- R1: After reset, no entry is valid, every lookup misses and `inv_done` is low.
- R2: A lookup that matches a valid entry raises `lk_hit` combinationally in the same cycle and returns the entry's physical page, permissions (bit 0 read, bit 1 write, bit 2 execute) and memory type unchanged.
- R3: A match needs an equal page number, an equal guest flag, and an equal guest identifier when that flag is set. If the entry's process flag is set, the lookup must also carry a set process flag and an equal process identifier.
- R4: An entry stored with its process flag clear hits for any lookup whose page and guest fields match, whatever process fields the lookup carries.
- R5: A fill whose page, flags and identifiers all equal those of a valid entry rewrites that entry, does not allocate a new slot and does not move the victim pointer.
- R6: A fill for a new key is written to the slot under the victim pointer, which starts at slot 0 and steps by one with wraparound. Once the cache is full, the oldest allocation is evicted first.
- R7: Invalidation scope 0 clears every entry.
- R8: Scope 1 clears the entries whose guest flag is set and whose guest identifier equals `inv_gid`. Entries with no guest tag, or with another guest identifier, stay valid.
- R9: Scope 2 clears the entries whose guest and process flags are both set and whose identifiers both equal the command's. Entries of the same guest that have no process tag stay valid.
- R10: Scope 3 clears the entries with page `inv_vpn`, guest flag set and guest identifier `inv_gid`, and with either a clear process flag or process identifier `inv_pid`.
- R11: A lookup in the same cycle as an invalidation that clears its matching entry reports a miss. A lookup whose entry the invalidation does not cover still hits.
- R12: A fill presented in the same cycle as any invalidation is discarded and the victim pointer holds.
- R13: `inv_done` goes high for exactly one cycle, in the cycle after an invalidation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_gid_vld | input | 1 | Lookup carries a guest tag |
| lk_gid | input | GID_W | Lookup guest identifier |
| lk_pid_vld | input | 1 | Lookup carries a process tag |
| lk_pid | input | PID_W | Lookup process identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page on hit |
| lk_perm | output | 3 | Permissions on hit |
| lk_mtype | output | 2 | Memory type on hit |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_ppn | input | PPN_W | Fill physical page number |
| fl_perm | input | 3 | Fill permissions |
| fl_mtype | input | 2 | Fill memory type |
| fl_gid_vld | input | 1 | Fill guest flag |
| fl_gid | input | GID_W | Fill guest identifier |
| fl_pid_vld | input | 1 | Fill process flag |
| fl_pid | input | PID_W | Fill process identifier |
| inv_valid | input | 1 | Invalidation command |
| inv_scope | input | 2 | 0 all, 1 guest, 2 guest and process, 3 page |
| inv_vpn | input | VPN_W | Page for scope 3 |
| inv_gid | input | GID_W | Guest identifier for scopes 1 to 3 |
| inv_pid | input | PID_W | Process identifier for scopes 2 and 3 |
| inv_done | output | 1 | Invalidation completion pulse |

## Verification
The bench builds the cache with four entries and keeps the default address and identifier widths. With four entries, a handful of fills is enough to fill the store, wrap the victim pointer and force an eviction. An overwrite that wrongly allocated a second slot would then evict a different entry from the one expected. That difference between the two eviction orders is what exposes a broken in-place overwrite. The tag mix is chosen so that each invalidation scope has both an entry it must clear and a nearby entry it must leave alone.

// File: rtl/xlat_ctx_cache.sv
module xlat_ctx_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 45,
  parameter int PPN_W   = 44,
  parameter int GID_W   = 16,
  parameter int PID_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_gid_vld,
  input  logic [GID_W-1:0] lk_gid,
  input  logic             lk_pid_vld,
  input  logic [PID_W-1:0] lk_pid,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [2:0]       lk_perm,
  output logic [1:0]       lk_mtype,
  input  logic             fl_valid,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PPN_W-1:0] fl_ppn,
  input  logic [2:0]       fl_perm,
  input  logic [1:0]       fl_mtype,
  input  logic             fl_gid_vld,
  input  logic [GID_W-1:0] fl_gid,
  input  logic             fl_pid_vld,
  input  logic [PID_W-1:0] fl_pid,
  input  logic             inv_valid,
  input  logic [1:0]       inv_scope,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [GID_W-1:0] inv_gid,
  input  logic [PID_W-1:0] inv_pid,
  output logic             inv_done
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] e_vld;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [2:0]         e_perm [ENTRIES];
  logic [1:0]         e_mt [ENTRIES];
  logic               e_gv [ENTRIES];
  logic [GID_W-1:0]   e_gid [ENTRIES];
  logic               e_pv [ENTRIES];
  logic [PID_W-1:0]   e_pid [ENTRIES];

  logic [ENTRIES-1:0] hit_vec, kill_vec, same_vec, live_vec;
  logic [IDX_W-1:0]   ptr, sel, same_idx, widx;
  logic               fl_take, fl_same;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = e_vld[i] && (e_vpn[i] == lk_vpn) && (e_gv[i] == lk_gid_vld) &&
                   (!e_gv[i] || (e_gid[i] == lk_gid)) &&
                   (!e_pv[i] || (lk_pid_vld && (e_pid[i] == lk_pid)));
      same_vec[i] = e_vld[i] && (e_vpn[i] == fl_vpn) && (e_gv[i] == fl_gid_vld) &&
                    (!e_gv[i] || (e_gid[i] == fl_gid)) && (e_pv[i] == fl_pid_vld) &&
                    (!e_pv[i] || (e_pid[i] == fl_pid));
      unique case (inv_scope)
        2'd0: kill_vec[i] = 1'b1;
        2'd1: kill_vec[i] = e_gv[i] && (e_gid[i] == inv_gid);
        2'd2: kill_vec[i] = e_gv[i] && (e_gid[i] == inv_gid) && e_pv[i] && (e_pid[i] == inv_pid);
        default: kill_vec[i] = (e_vpn[i] == inv_vpn) && e_gv[i] && (e_gid[i] == inv_gid) &&
                               (!e_pv[i] || (e_pid[i] == inv_pid));
      endcase
      kill_vec[i] = kill_vec[i] && inv_valid;
    end
  end

  assign live_vec = hit_vec & ~kill_vec;

  always_comb begin
    sel = '0;
    same_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (live_vec[i]) sel = IDX_W'(i);
      if (same_vec[i]) same_idx = IDX_W'(i);
    end
  end

  assign lk_hit   = lk_valid && (|live_vec);
  assign lk_ppn   = lk_hit ? e_ppn[sel]  : '0;
  assign lk_perm  = lk_hit ? e_perm[sel] : '0;
  assign lk_mtype = lk_hit ? e_mt[sel]   : '0;

  assign fl_take = fl_valid && !inv_valid;
  assign fl_same = |same_vec;
  assign widx    = fl_same ? same_idx : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld    <= '0;
      ptr      <= '0;
      inv_done <= 1'b0;
    end else begin
      inv_done <= inv_valid;
      e_vld    <= e_vld & ~kill_vec;
      if (fl_take) begin
        e_vld[widx] <= 1'b1;
        if (!fl_same) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fl_take) begin
      e_vpn[widx]  <= fl_vpn;
      e_ppn[widx]  <= fl_ppn;
      e_perm[widx] <= fl_perm;
      e_mt[widx]   <= fl_mtype;
      e_gv[widx]   <= fl_gid_vld;
      e_gid[widx]  <= fl_gid;
      e_pv[widx]   <= fl_pid_vld;
      e_pid[widx]  <= fl_pid;
    end
  end

  AST_ONE_KEY_COPY: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(same_vec)); // R5
  AST_PTR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !inv_valid && !fl_same) |=> (ptr != $past(ptr))); // R6
  AST_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_scope == 2'd0) |=> (e_vld == '0)); // R7
  AST_INV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_scope == 2'd0) |-> !lk_hit); // R11
  AST_FILL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && inv_valid) |=> $stable(ptr)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> inv_done); // R13

endmodule

// File: tb/xlat_ctx_cache_bench.sv
`timescale 1ns/1ps
module xlat_ctx_cache_bench;
  localparam int VW = 45, PW = 44, GW = 16, QW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_gid_vld = 0, lk_pid_vld = 0;
  logic [VW-1:0] lk_vpn = '0;
  logic [GW-1:0] lk_gid = '0;
  logic [QW-1:0] lk_pid = '0;
  logic lk_hit;
  logic [PW-1:0] lk_ppn;
  logic [2:0] lk_perm;
  logic [1:0] lk_mtype;
  logic fl_valid = 0, fl_gid_vld = 0, fl_pid_vld = 0;
  logic [VW-1:0] fl_vpn = '0;
  logic [PW-1:0] fl_ppn = '0;
  logic [2:0] fl_perm = '0;
  logic [1:0] fl_mtype = '0;
  logic [GW-1:0] fl_gid = '0;
  logic [QW-1:0] fl_pid = '0;
  logic inv_valid = 0;
  logic [1:0] inv_scope = '0;
  logic [VW-1:0] inv_vpn = '0;
  logic [GW-1:0] inv_gid = '0;
  logic [QW-1:0] inv_pid = '0;
  logic inv_done;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xlat_ctx_cache #(.ENTRIES(4)) u_xlat_ctx_cache (
    .clk, .rst_n, .lk_valid, .lk_vpn, .lk_gid_vld, .lk_gid, .lk_pid_vld, .lk_pid,
    .lk_hit, .lk_ppn, .lk_perm, .lk_mtype, .fl_valid, .fl_vpn, .fl_ppn, .fl_perm,
    .fl_mtype, .fl_gid_vld, .fl_gid, .fl_pid_vld, .fl_pid, .inv_valid, .inv_scope,
    .inv_vpn, .inv_gid, .inv_pid, .inv_done);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input int vpn, input int ppn, input int gv, input int g, input int pv, input int p);
    @(negedge clk);
    fl_valid = 1; fl_vpn = VW'(vpn); fl_ppn = PW'(ppn); fl_perm = 3'(ppn); fl_mtype = 2'(ppn);
    fl_gid_vld = gv[0]; fl_gid = GW'(g); fl_pid_vld = pv[0]; fl_pid = QW'(p);
    @(negedge clk);
    fl_valid = 0;
  endtask

  task automatic look(input int vpn, input int gv, input int g, input int pv, input int p,
                      input bit eh, input int eppn, input string req);
    @(negedge clk);
    lk_valid = 1; lk_vpn = VW'(vpn); lk_gid_vld = gv[0]; lk_gid = GW'(g);
    lk_pid_vld = pv[0]; lk_pid = QW'(p);
    #1;
    chk(lk_hit == eh, req, 64'(lk_hit), 64'(eh));
    if (eh) begin
      chk(lk_ppn == PW'(eppn), req, 64'(lk_ppn), 64'(eppn));
      chk(lk_perm == 3'(eppn) && lk_mtype == 2'(eppn), req, {lk_perm, lk_mtype}, 64'({3'(eppn), 2'(eppn)}));
    end
    lk_valid = 0;
  endtask

  task automatic inv(input int scope, input int vpn, input int g, input int p);
    @(negedge clk);
    inv_valid = 1; inv_scope = 2'(scope); inv_vpn = VW'(vpn); inv_gid = GW'(g); inv_pid = QW'(p);
    @(negedge clk);
    chk(inv_done == 1'b1, "R13 done high", 64'(inv_done), 64'd1);
    inv_valid = 0;
    @(negedge clk);
    chk(inv_done == 1'b0, "R13 done single cycle", 64'(inv_done), 64'd0);
  endtask

  task automatic t_reset();
    look(0, 0, 0, 0, 0, 0, 0, "R1 empty miss");
    look('h100, 1, 5, 1, 7, 0, 0, "R1 empty miss tagged");
    chk(inv_done == 1'b0, "R1 done low", 64'(inv_done), 64'd0);
  endtask

  task automatic t_match();
    fill('h100, 'hABC, 1, 5, 1, 7);
    look('h100, 1, 5, 1, 7, 1, 'hABC, "R2 hit data");
    look('h100, 1, 5, 1, 8, 0, 0, "R3 other pid");
    look('h100, 1, 6, 1, 7, 0, 0, "R3 other gid");
    look('h100, 1, 5, 0, 7, 0, 0, "R3 no pid flag");
    look('h101, 1, 5, 1, 7, 0, 0, "R3 other page");
    fill('h200, 'h222, 1, 5, 0, 0);
    look('h200, 1, 5, 1, 9, 1, 'h222, "R4 any pid");
    look('h200, 1, 5, 0, 0, 1, 'h222, "R4 no pid");
  endtask

  task automatic t_replace();
    fill('h100, 'hDEF, 1, 5, 1, 7);
    look('h100, 1, 5, 1, 7, 1, 'hDEF, "R5 overwritten");
    fill('h300, 'h333, 1, 5, 1, 7);
    fill('h301, 'h334, 1, 5, 1, 8);
    fill('h302, 'h335, 1, 6, 1, 7);
    look('h100, 1, 5, 1, 7, 0, 0, "R6 oldest evicted");
    look('h200, 1, 5, 0, 0, 1, 'h222, "R5 no second slot");
    look('h300, 1, 5, 1, 7, 1, 'h333, "R6 kept");
    look('h302, 1, 6, 1, 7, 1, 'h335, "R6 wrapped slot");
  endtask

  task automatic t_scopes();
    inv(3, 'h300, 5, 7);
    look('h300, 1, 5, 1, 7, 0, 0, "R10 page cleared");
    look('h301, 1, 5, 1, 8, 1, 'h334, "R10 neighbour kept");
    inv(3, 'h200, 5, 9);
    look('h200, 1, 5, 0, 0, 0, 0, "R10 pid-less cleared");
    fill('h210, 'h211, 1, 5, 0, 0);
    inv(2, 0, 5, 8);
    look('h301, 1, 5, 1, 8, 0, 0, "R9 pair cleared");
    look('h210, 1, 5, 0, 0, 1, 'h211, "R9 pid-less kept");
    look('h302, 1, 6, 1, 7, 1, 'h335, "R9 other guest kept");
    inv(1, 0, 6, 0);
    look('h302, 1, 6, 1, 7, 0, 0, "R8 guest cleared");
    look('h210, 1, 5, 0, 0, 1, 'h211, "R8 other guest kept");
    fill('h400, 'h401, 0, 0, 0, 0);
    inv(1, 0, 5, 0);
    look('h210, 1, 5, 0, 0, 0, 0, "R8 guest 5 cleared");
    look('h400, 0, 0, 0, 0, 1, 'h401, "R8 untagged kept");
    inv(0, 0, 0, 0);
    look('h400, 0, 0, 0, 0, 0, 0, "R7 all cleared");
  endtask

  task automatic t_same_cycle();
    fill('h500, 'h501, 1, 1, 1, 1);
    @(negedge clk);
    lk_valid = 1; lk_vpn = 'h500; lk_gid_vld = 1; lk_gid = 1; lk_pid_vld = 1; lk_pid = 1;
    inv_valid = 1; inv_scope = 2'd1; inv_gid = 2;
    #1;
    chk(lk_hit == 1'b1, "R11 uncovered hits", 64'(lk_hit), 64'd1);
    @(negedge clk);
    inv_valid = 1; inv_scope = 2'd3; inv_vpn = 'h500; inv_gid = 1; inv_pid = 1;
    #1;
    chk(lk_hit == 1'b0, "R11 covered misses", 64'(lk_hit), 64'd0);
    @(negedge clk);
    inv_valid = 0; lk_valid = 0;
    @(negedge clk);
    fl_valid = 1; fl_vpn = 'h600; fl_ppn = 'h601; fl_gid_vld = 1; fl_gid = 3; fl_pid_vld = 0;
    inv_valid = 1; inv_scope = 2'd1; inv_gid = 9;
    @(negedge clk);
    fl_valid = 0; inv_valid = 0;
    look('h600, 1, 3, 0, 0, 0, 0, "R12 fill dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_match();
    t_replace();
    t_scopes();
    t_same_cycle();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule